// File: doc/BRIEF.md
# Stub Gathering and Serial Frame Formatter

Once per bunch crossing this block takes a vector of stub-candidate flags, one per half-strip position, each with a 5-bit raw bend. It keeps at most three candidates, lowest position first, and raises an overflow flag when more were present. Each kept bend passes through a 32-entry programmable table that yields a 4-bit code. The three addresses, the three codes and four per-frame flags are packed into five 8-bit lane words. The words are shifted out MSB first on five serial lanes, one bit per fast clock, so one 8-bit frame fills one crossing period.

Every block runs on the fast bit clock. `frame_stb` is high for one fast cycle per crossing. The input side is a valid/ready stream. `in_ready` is high only in the strobe cycle, and a crossing is taken only when `in_valid` and `in_ready` are both high. The source cannot stall the block. A crossing not presented at the strobe is lost, and that slot goes out as an empty frame. The output lanes have no back-pressure: they are a fixed-rate bit stream. A crossing accepted at one strobe is selected, translated and loaded into the lane shifters at the next strobe. This gives one frame of latency and leaves the selection a full frame period to settle.

Top module: `stub_fmt_top`

## Requirements
- R1: The first bit of every frame on lane 5 (`lane_o[4]`, bit 7 of its word) is the sync bit and is always 1.
- R2: Of the accepted candidates, the one at the lowest position is stub 1, the next is stub 2 and the third is stub 3. Their addresses appear on lanes 1, 2 and 3 (`lane_o[0..2]`), MSB first, one bit per clock starting the cycle after the loading strobe.
- R3: `ovf_o` is 1 for a frame exactly when the crossing held more than three candidates. It changes only on the clock edge that loads a frame.
- R4: A stub address is the 8-bit half-strip position index of the candidate. Bit 0 is the half-strip bit, so position 2n+1 lies between strips n and n+1.
- R5: A stub slot with no candidate sends address 0 and bend code 0.
- R6: Lane 4 (`lane_o[3]`) sends stub 2's 4-bit code and then stub 1's code. The low four bits of lane 5 carry stub 3's code. Each code is the table entry indexed by that stub's 5-bit raw bend.
- R7: Lane 5's word is, MSB first: sync, error flag, hit-OR flag, start-of-frame flag, then stub 3's code.
- R8: After reset, table entry i holds the low four bits of i.
- R9: With `lut_we` high at a clock edge, `lut_wdata` is written to entry `lut_addr`. Frames loaded after that edge use the new entry.
- R10: `in_ready` equals `frame_stb`. Data taken at one strobe is sent after the next strobe. A strobe with `in_valid` low yields a frame with no stubs, zero flags and sync 1.
- R11: While reset is held and after it until the first strobe, all lanes and `ovf_o` are 0.
- R12: Once all 8 bits of a frame have been sent with no new strobe, every lane is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle crossing strobe |
| in_valid | input | 1 | Crossing data valid |
| in_ready | output | 1 | Crossing accepted this cycle when valid |
| in_cand | input | N_POS | Candidate flag per half-strip position |
| in_bend | input | N_POS*5 | 5-bit raw bend per position, position p at bits [5p+4:5p] |
| in_err | input | 1 | Error flag for the crossing |
| in_hit_any | input | 1 | OR of all hit channels |
| in_sof | input | 1 | Start-of-frame flag |
| lut_we | input | 1 | Bend table write enable |
| lut_addr | input | 5 | Bend table entry |
| lut_wdata | input | 4 | Bend table write data |
| lane_o | output | 5 | Serial lanes, bit k is lane k+1 |
| ovf_o | output | 1 | More than three candidates in the frame |

## Verification
A wrong choice in the priority chain shows up on lanes 1 to 3 within one frame after the loading strobe. It appears as addresses out of order, a slot filled twice, or a nonzero address in an empty slot. A corrupted table entry or a miswired packing stays hidden until a candidate whose raw bend indexes that entry reaches the lanes. It is then visible in the very next 8-bit word on lane 4 or lane 5. A fault in the shifters or the frame counter breaks the sync bit or the zero tail on the next frame.

// File: rtl/stub_fmt_pkg.sv
package stub_fmt_pkg;
  localparam int LANE_BITS  = 8;
  localparam int N_LANES    = 5;
  localparam int N_STUBS    = 3;
  localparam int ADDR_W     = 8;
  localparam int RAW_BEND_W = 5;
  localparam int CODE_W     = 4;
  localparam int LUT_DEPTH  = 1 << RAW_BEND_W;

  typedef struct packed {
    logic                  used;
    logic [ADDR_W-1:0]     addr;
    logic [RAW_BEND_W-1:0] bend;
  } stub_t;

  typedef logic [N_LANES-1:0][LANE_BITS-1:0] frame_t;
endpackage

// File: rtl/stub_pick.sv
module stub_pick
  import stub_fmt_pkg::*;
#(
  parameter int N_POS = 254
) (
  input  logic [N_POS-1:0]            cand,
  input  logic [N_POS*RAW_BEND_W-1:0] bends,
  output stub_t [N_STUBS-1:0]         stubs,
  output logic                        ovf
);
  // remain[s] holds the candidates not yet claimed by slots below s
  logic [N_STUBS:0][N_POS-1:0] remain;
  assign remain[0] = cand;

  for (genvar s = 0; s < N_STUBS; s++) begin : g_slot
    logic                  found;
    logic [ADDR_W-1:0]     idx;
    logic [RAW_BEND_W-1:0] bnd;
    logic [N_POS-1:0]      rest;

    always_comb begin
      found = 1'b0;
      idx   = '0;
      bnd   = '0;
      for (int i = N_POS - 1; i >= 0; i--) begin
        if (remain[s][i]) begin
          found = 1'b1;
          idx   = ADDR_W'(i);
          bnd   = bends[i*RAW_BEND_W +: RAW_BEND_W];
        end
      end
      rest = remain[s];
      for (int i = 0; i < N_POS; i++) begin
        if (found && (ADDR_W'(i) == idx)) rest[i] = 1'b0;
      end
    end

    assign remain[s+1]   = rest;
    assign stubs[s].used = found;
    assign stubs[s].addr = idx;
    assign stubs[s].bend = bnd;
  end

  assign ovf = |remain[N_STUBS];
endmodule

// File: rtl/bend_lut.sv
module bend_lut
  import stub_fmt_pkg::*;
#(
  parameter int N_RD = N_STUBS
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we,
  input  logic [RAW_BEND_W-1:0]                waddr,
  input  logic [CODE_W-1:0]                    wdata,
  input  logic [N_RD-1:0]                      rd_used,
  input  logic [N_RD-1:0][RAW_BEND_W-1:0]      rd_raw,
  output logic [N_RD-1:0][CODE_W-1:0]          rd_code
);
  logic [CODE_W-1:0] tbl [LUT_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LUT_DEPTH; i++) tbl[i] <= CODE_W'(i);
    end else if (we) begin
      tbl[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_code[r] = rd_used[r] ? tbl[rd_raw[r]] : '0;
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
  import stub_fmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  frame_t             word,
  output logic [N_LANES-1:0] lanes
);
  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    logic [LANE_BITS-1:0] sr;
    always_ff @(posedge clk) begin
      if (!rst_n)     sr <= '0;
      else if (load)  sr <= word[k];
      else            sr <= {sr[LANE_BITS-2:0], 1'b0};
    end
    assign lanes[k] = sr[LANE_BITS-1];
  end
endmodule

// File: rtl/stub_fmt_top.sv
module stub_fmt_top
  import stub_fmt_pkg::*;
#(
  parameter int N_POS = 254
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_stb,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [N_POS-1:0]              in_cand,
  input  logic [N_POS*RAW_BEND_W-1:0]   in_bend,
  input  logic                          in_err,
  input  logic                          in_hit_any,
  input  logic                          in_sof,
  input  logic                          lut_we,
  input  logic [RAW_BEND_W-1:0]         lut_addr,
  input  logic [CODE_W-1:0]             lut_wdata,
  output logic [N_LANES-1:0]            lane_o,
  output logic                          ovf_o
);
  localparam int BEND_BUS = N_POS * RAW_BEND_W;

  logic                take;
  logic [N_POS-1:0]    cap_cand;
  logic [BEND_BUS-1:0] cap_bend;
  logic                cap_err, cap_hit, cap_sof;

  assign in_ready = frame_stb;
  assign take     = frame_stb && in_valid;

  // Capture stage: one crossing held for a full frame period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_cand <= '0;
      cap_bend <= '0;
      cap_err  <= 1'b0;
      cap_hit  <= 1'b0;
      cap_sof  <= 1'b0;
    end else if (frame_stb) begin
      cap_cand <= take ? in_cand    : '0;
      cap_bend <= take ? in_bend    : '0;
      cap_err  <= take && in_err;
      cap_hit  <= take && in_hit_any;
      cap_sof  <= take && in_sof;
    end
  end

  stub_t [N_STUBS-1:0] stubs;
  logic                pick_ovf;

  stub_pick #(.N_POS(N_POS)) u_pick (
    .cand  (cap_cand),
    .bends (cap_bend),
    .stubs (stubs),
    .ovf   (pick_ovf)
  );

  logic [N_STUBS-1:0]                 used;
  logic [N_STUBS-1:0][RAW_BEND_W-1:0] raw;
  logic [N_STUBS-1:0][CODE_W-1:0]     code;

  for (genvar s = 0; s < N_STUBS; s++) begin : g_map
    assign used[s] = stubs[s].used;
    assign raw[s]  = stubs[s].bend;
  end

  bend_lut #(.N_RD(N_STUBS)) u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (lut_we),
    .waddr   (lut_addr),
    .wdata   (lut_wdata),
    .rd_used (used),
    .rd_raw  (raw),
    .rd_code (code)
  );

  frame_t word;
  always_comb begin
    for (int s = 0; s < N_STUBS; s++) word[s] = stubs[s].addr;
    word[3] = {code[1], code[0]};
    word[4] = {1'b1, cap_err, cap_hit, cap_sof, code[2]};
  end

  lane_shifter u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (frame_stb),
    .word  (word),
    .lanes (lane_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         ovf_o <= 1'b0;
    else if (frame_stb) ovf_o <= pick_ovf;
  end
endmodule

// File: rtl/stub_fmt_chk.sv
module stub_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_stb,
  input logic [4:0] lane_o,
  input logic       ovf_o
);
  // cnt: cycles since the last loading strobe, saturating at 8
  logic [3:0] cnt;
  logic [6:0] des0, des1, des2;
  logic [7:0] w0, w1, w2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= 4'd8;
      des0 <= '0;
      des1 <= '0;
      des2 <= '0;
    end else begin
      if (frame_stb)      cnt <= 4'd0;
      else if (cnt < 4'd8) cnt <= cnt + 4'd1;
      des0 <= {des0[5:0], lane_o[0]};
      des1 <= {des1[5:0], lane_o[1]};
      des2 <= {des2[5:0], lane_o[2]};
    end
  end

  assign w0 = {des0, lane_o[0]};
  assign w1 = {des1, lane_o[1]};
  assign w2 = {des2, lane_o[2]};

  p_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> lane_o[4]);

  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(ovf_o));

  p_ovf_three_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 4'd7 && ovf_o) |-> (w2 != 8'd0));

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 4'd7 && w1 != 8'd0) |-> (w1 > w0 && (w2 == 8'd0 || w2 > w1)));

  p_empty_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 4'd7 && w1 == 8'd0) |-> (w2 == 8'd0));

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 4'd8) |-> (lane_o == 5'd0));
endmodule

bind stub_fmt_top stub_fmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_stb (frame_stb),
  .lane_o    (lane_o),
  .ovf_o     (ovf_o)
);

// File: tb/stub_fmt_top_tb.sv
`timescale 1ns/1ps
module stub_fmt_top_tb;
  localparam int NP = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame_stb = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [NP-1:0]   in_cand = '0;
  logic [NP*5-1:0] in_bend = '0;
  logic            in_err = 1'b0, in_hit_any = 1'b0, in_sof = 1'b0;
  logic            lut_we = 1'b0;
  logic [4:0]      lut_addr = '0;
  logic [3:0]      lut_wdata = '0;
  logic [4:0]      lane_o;
  logic            ovf_o;

  always #2 clk = ~clk;

  stub_fmt_top #(.N_POS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .in_valid(in_valid),
    .in_ready(in_ready), .in_cand(in_cand), .in_bend(in_bend), .in_err(in_err),
    .in_hit_any(in_hit_any), .in_sof(in_sof), .lut_we(lut_we),
    .lut_addr(lut_addr), .lut_wdata(lut_wdata), .lane_o(lane_o), .ovf_o(ovf_o)
  );

  int checks = 0;
  int failures = 0;
  int fr = 0;
  bit done = 1'b0;
  logic [3:0] lut_model [32];
  string lut_tag = "R8";

  logic [NP-1:0]   prev_c = '0;
  logic [NP*5-1:0] prev_bf = '0;
  logic            prev_v = 1'b0, prev_e = 1'b0, prev_h = 1'b0, prev_s = 1'b0;
  logic [31:0]     lcg = 32'h1234_5678;

  task automatic ck(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s frame %0d got %h expected %h", req, fr, got, exp);
    end
  endtask

  function automatic void model(input logic [NP-1:0] c, input logic [NP*5-1:0] bf,
                                input logic v, e, h, s,
                                output logic [4:0][7:0] w, output logic o);
    logic [7:0] a [3];
    logic [3:0] cd [3];
    int n = 0;
    for (int k = 0; k < 3; k++) begin a[k] = '0; cd[k] = '0; end
    if (!v) begin c = '0; e = 1'b0; h = 1'b0; s = 1'b0; end
    for (int p = 0; p < NP; p++) begin
      if (c[p]) begin
        if (n < 3) begin
          a[n]  = 8'(p);
          cd[n] = lut_model[bf[p*5 +: 5]];
        end
        n++;
      end
    end
    o = (n > 3);
    w[0] = a[0];
    w[1] = a[1];
    w[2] = a[2];
    w[3] = {cd[1], cd[0]};
    w[4] = {1'b1, e, h, s, cd[2]};
  endfunction

  function automatic logic [31:0] step(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic run_frame(input logic [NP-1:0] c, input logic v, e, h, s);
    logic [4:0][7:0] ew, gw;
    logic            eo;
    logic [NP*5-1:0] bf;
    model(prev_c, prev_bf, prev_v, prev_e, prev_h, prev_s, ew, eo);
    for (int p = 0; p < NP; p++) bf[p*5 +: 5] = 5'(p * 11 + fr * 5 + 1);
    in_cand = c; in_bend = bf; in_valid = v;
    in_err = e; in_hit_any = h; in_sof = s;
    frame_stb = 1'b1;
    #1;
    ck("R10 in_ready at strobe", {7'd0, in_ready}, 8'd1);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk);
      if (b == 7) begin
        frame_stb = 1'b0;
        ck("R3 overflow flag", {7'd0, ovf_o}, {7'd0, eo});
      end
      for (int k = 0; k < 5; k++) gw[k][b] = lane_o[k];
    end
    ck("R2 R4 R5 R10 stub1 address lane", gw[0], ew[0]);
    ck("R2 R4 R5 stub2 address lane", gw[1], ew[1]);
    ck("R2 R4 R5 stub3 address lane", gw[2], ew[2]);
    ck({"R6 R5 bend codes lane4 ", lut_tag}, gw[3], ew[3]);
    ck({"R1 R7 R6 flags lane5 ", lut_tag}, gw[4], ew[4]);
    prev_c = c; prev_bf = bf; prev_v = v; prev_e = e; prev_h = h; prev_s = s;
    fr++;
  endtask

  task automatic idle_check(input int n);
    @(negedge clk);
    ck("R12 lanes low after frame", {3'd0, lane_o}, 8'd0);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      ck("R12 lanes stay low", {3'd0, lane_o}, 8'd0);
    end
  endtask

  task automatic wr_lut(input logic [4:0] a, input logic [3:0] d);
    lut_we = 1'b1; lut_addr = a; lut_wdata = d;
    @(negedge clk);
    lut_we = 1'b0;
    lut_model[a] = d;
  endtask

  initial begin
    #600000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired at frame %0d got hang expected finish", fr);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) lut_model[i] = 4'(i);
    repeat (4) @(negedge clk);
    ck("R11 lanes in reset", {3'd0, lane_o}, 8'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      ck("R11 lanes after reset", {3'd0, lane_o}, 8'd0);
      ck("R11 ovf after reset", {7'd0, ovf_o}, 8'd0);
    end

    // Phase 1: identity table, every vector with at most four candidates
    for (int v = 0; v < (1 << NP); v++) begin
      if ($countones(v) <= 4) begin
        logic [31:0] f = 32'(fr);
        run_frame(NP'(v), (fr % 13) != 5, f[0], f[1], f[2]);
      end
    end
    run_frame(16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1);
    run_frame(16'h001F, 1'b1, 1'b0, 1'b1, 1'b0);
    run_frame(16'hAAAA, 1'b1, 1'b1, 1'b0, 1'b0);
    run_frame(16'h8421, 1'b1, 1'b0, 1'b0, 1'b1);
    run_frame(16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 60; i++) begin
      lcg = step(lcg);
      run_frame(lcg[23:8], 1'b1, lcg[3], lcg[4], lcg[5]);
    end
    run_frame('0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_check(10);

    // Phase 2: programmed table
    for (int i = 0; i < 32; i++) wr_lut(5'(i), 4'((i * 7 + 3) & 15));
    lut_tag = "R9";
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      lcg = step(lcg); a = lcg;
      lcg = step(lcg); b = lcg;
      run_frame((i % 2 == 0) ? (a[23:8] & b[23:8]) : a[23:8],
                (i % 17) != 3, b[1], b[2], b[3]);
    end
    run_frame('0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_check(10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule